// File: doc/BRIEF.md
# Half-Duplex Collision Detector

This block decides when a combined 10/100 Ethernet MAC/PHY reports a collision to its MAC. It watches qualified transmit-activity and receive-activity flags and raises a registered collision flag when both are present on a half-duplex link. Full duplex, a failed link or diagnostic loopback suppress the flag entirely. A collision-test control overrides that suppression: it loops the MAC's internal transmit enable onto the collision flag and turns the twisted-pair transmitter off.

At 10 Mbps two more sources raise the collision flag: a signal-quality-error test pulse and a jabber event. While the flag is high at 10 Mbps, the receive nibble handed to the MAC is replaced by zeros. At 100 Mbps receive data keeps flowing unchanged through a collision, so the MAC decides when to stop its own transmission.

The reset input is asynchronous and active low. Its release is synchronised internally over a parameterised number of flops. The collision flag stays low until that release has passed through.

Top module: `hdx_col_detect`

## Requirements
- R1: While `rst_n` is low, and for the first `SYNC_STAGES` (default 2) rising edges after it goes high, `col_out` is 0 whatever the other inputs are.
- R2: On a half-duplex, linked, non-loopback port with `col_test` low, `tx_act` and `rx_act` both high at a rising edge set `col_out` to 1 after that edge.
- R3: With `col_test` low, `col_out` is 0 after any edge at which `full_dpx`, `link_down` or `lpbk_en` is high. This holds even when activity overlaps or an SQE or jabber event is present.
- R4: With `col_test` high, `col_out` after an edge equals the `tx_en` sampled at that edge, whatever the duplex, link and loopback inputs are. `tp_tx_off` is high exactly while `col_test` is high.
- R5: At 10 Mbps (`spd_100` = 0) on an ungated port, `sqe_evt` high at an edge sets `col_out` to 1 after it, even with no activity.
- R6: At 10 Mbps on an ungated port, `jab_evt` high at an edge sets `col_out` to 1 after it, even with no activity.
- R7: At 100 Mbps (`spd_100` = 1), `sqe_evt` and `jab_evt` have no effect on `col_out`.
- R8: At 10 Mbps, `rxd_out` is all zeros while `col_out` is 1, and equals `rxd_in` while `col_out` is 0.
- R9: At 100 Mbps, `rxd_out` equals `rxd_in` at all times, including during a collision.
- R10: Outside test mode, `col_out` goes to 0 after the first edge at which `tx_act` or `rx_act` is low. At 10 Mbps it stays 1 if `sqe_evt` or `jab_evt` is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_dpx | input | 1 | Port is full duplex |
| link_down | input | 1 | Link-fail state |
| lpbk_en | input | 1 | Diagnostic loopback enabled |
| col_test | input | 1 | Collision-test control |
| tx_en | input | 1 | Internal transmit enable from the MAC |
| tx_act | input | 1 | Transmission on the line |
| rx_act | input | 1 | Qualified receive activity |
| sqe_evt | input | 1 | SQE test in progress (10 Mbps) |
| jab_evt | input | 1 | Jabber detected (10 Mbps) |
| rxd_in | input | NIB_W | Receive nibble from the decoder |
| rxd_out | output | NIB_W | Receive nibble to the MAC |
| col_out | output | 1 | Registered collision flag to the MAC |
| tp_tx_off | output | 1 | Disable twisted-pair transmit outputs |

## Verification
The hardest case to reach is a 10 Mbps collision held up by an SQE event after the activity overlap has ended. The bench builds a real overlap first, drops transmit activity in the same cycle that it raises `sqe_evt`, and then releases the event. This shows the hold lasts for exactly one edge. It also shows that the receive nibble returns once the flag falls. Collision-test mode is entered with full duplex set, so that its priority over the gating shows at the port.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_OVERLAP = 2'd1,
    SRC_EVENT   = 2'd2,
    SRC_TEST    = 2'd3
  } col_src_e;
endpackage

// File: rtl/hcd_rst_sync.sv
module hcd_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stg_q;
  logic [LAST:0] stg_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb stg_d = 1'b1;
    end else begin : g_many
      always_comb stg_d = {stg_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_ok = stg_q[LAST];
endmodule

// File: rtl/hcd_qualify.sv
module hcd_qualify
  import hcd_pkg::*;
(
  input  logic     spd_100,
  input  logic     full_dpx,
  input  logic     link_down,
  input  logic     lpbk_en,
  input  logic     col_test,
  input  logic     tx_en,
  input  logic     tx_act,
  input  logic     rx_act,
  input  logic     sqe_evt,
  input  logic     jab_evt,
  output logic     col_req,
  output col_src_e col_src
);
  logic gated;
  logic overlap;
  logic evt10;

  always_comb begin
    gated   = full_dpx | link_down | lpbk_en;
    overlap = tx_act & rx_act;
    evt10   = ~spd_100 & (sqe_evt | jab_evt);
    col_src = SRC_NONE;
    if (col_test)     col_src = tx_en ? SRC_TEST : SRC_NONE;
    else if (gated)   col_src = SRC_NONE;
    else if (overlap) col_src = SRC_OVERLAP;
    else if (evt10)   col_src = SRC_EVENT;
    col_req = (col_src != SRC_NONE);
  end
endmodule

// File: rtl/hcd_rx_mask.sv
module hcd_rx_mask #(
  parameter int NIB_W = 4
) (
  input  logic             spd_100,
  input  logic             col_q,
  input  logic [NIB_W-1:0] rxd_in,
  output logic [NIB_W-1:0] rxd_out
);
  logic zero_en;

  always_comb zero_en = col_q & ~spd_100;

  generate
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      assign rxd_out[b] = rxd_in[b] & ~zero_en;
    end
  endgenerate
endmodule

// File: rtl/hdx_col_detect.sv
module hdx_col_detect
  import hcd_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_100,
  input  logic             full_dpx,
  input  logic             link_down,
  input  logic             lpbk_en,
  input  logic             col_test,
  input  logic             tx_en,
  input  logic             tx_act,
  input  logic             rx_act,
  input  logic             sqe_evt,
  input  logic             jab_evt,
  input  logic [NIB_W-1:0] rxd_in,
  output logic [NIB_W-1:0] rxd_out,
  output logic             col_out,
  output logic             tp_tx_off
);
  logic     rst_ok;
  logic     col_req;
  col_src_e col_src;
  logic     col_d;
  logic     col_q;

  hcd_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  hcd_qualify u_qual (
    .spd_100(spd_100), .full_dpx(full_dpx), .link_down(link_down),
    .lpbk_en(lpbk_en), .col_test(col_test), .tx_en(tx_en),
    .tx_act(tx_act), .rx_act(rx_act), .sqe_evt(sqe_evt),
    .jab_evt(jab_evt), .col_req(col_req), .col_src(col_src)
  );

  // next state: hold low until reset release has been synchronised
  always_comb col_d = rst_ok ? col_req : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= 1'b0;
    else        col_q <= col_d;
  end

  hcd_rx_mask #(.NIB_W(NIB_W)) u_mask (
    .spd_100(spd_100), .col_q(col_q), .rxd_in(rxd_in), .rxd_out(rxd_out)
  );

  assign col_out   = col_q;
  assign tp_tx_off = col_test;

  // R2: half-duplex overlap produces a collision
  a_r2_overlap_sets: assert property (@(posedge clk) disable iff (!rst_ok)
    (!col_test && !full_dpx && !link_down && !lpbk_en && tx_act && rx_act)
      |=> col_out);

  // R3: gating modes suppress the collision
  a_r3_gated_low: assert property (@(posedge clk) disable iff (!rst_ok)
    (!col_test && (full_dpx || link_down || lpbk_en)) |=> !col_out);

  // R4: test mode loops tx_en onto the collision flag
  a_r4_test_loop: assert property (@(posedge clk) disable iff (!rst_ok)
    col_test |=> (col_out == $past(tx_en)));

  // R7: 100 Mbps ignores SQE and jabber
  a_r7_fast_no_evt: assert property (@(posedge clk) disable iff (!rst_ok)
    (spd_100 && !col_test && !(tx_act && rx_act)) |=> !col_out);

  // R10: activity end drops the flag unless a 10 Mbps event holds it
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_ok)
    (!col_test && !(tx_act && rx_act) && !(!spd_100 && (sqe_evt || jab_evt)))
      |=> !col_out);

  // R8: 10 Mbps receive data zeroed during a collision
  a_r8_rx_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (col_out && !spd_100) |-> (rxd_out == '0));
endmodule

// File: tb/hdx_col_detect_bench.sv
`timescale 1ns/1ps
module hdx_col_detect_bench;
  localparam int NIB_W = 4;

  logic clk = 1'b0;
  logic rst_n, spd_100, full_dpx, link_down, lpbk_en, col_test, tx_en;
  logic tx_act, rx_act, sqe_evt, jab_evt;
  logic [NIB_W-1:0] rxd_in, rxd_out;
  logic col_out, tp_tx_off;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdx_col_detect #(.NIB_W(NIB_W), .SYNC_STAGES(2)) u_hdx_col_detect (
    .clk(clk), .rst_n(rst_n), .spd_100(spd_100), .full_dpx(full_dpx),
    .link_down(link_down), .lpbk_en(lpbk_en), .col_test(col_test),
    .tx_en(tx_en), .tx_act(tx_act), .rx_act(rx_act), .sqe_evt(sqe_evt),
    .jab_evt(jab_evt), .rxd_in(rxd_in), .rxd_out(rxd_out),
    .col_out(col_out), .tp_tx_off(tp_tx_off)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    spd_100 = 1'b1; full_dpx = 1'b0; link_down = 1'b0; lpbk_en = 1'b0;
    col_test = 1'b0; tx_en = 1'b0; tx_act = 1'b0; rx_act = 1'b0;
    sqe_evt = 1'b0; jab_evt = 1'b0; rxd_in = '0;
    step(); step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle();
    col_test = 1'b1; tx_en = 1'b1; tx_act = 1'b1; rx_act = 1'b1;
    step(); step();
    chk("R1 col in reset", col_out, 0);
    chk("R4 tp_tx_off follows col_test", tp_tx_off, 1);
    rst_n = 1'b1; step();
    chk("R1 col first edge after release", col_out, 0);
    idle();
    chk("R1 col idle after reset", col_out, 0);
  endtask

  task automatic t_overlap_100();
    idle();
    tx_act = 1'b1; rx_act = 1'b1; rxd_in = 4'h5; step();
    chk("R2 overlap 100M", col_out, 1);
    chk("R9 rxd passes at 100M", rxd_out, 5);
    rx_act = 1'b0; step();
    chk("R10 drop after rx ends", col_out, 0);
  endtask

  task automatic t_overlap_10();
    idle();
    spd_100 = 1'b0; tx_act = 1'b1; rx_act = 1'b1; rxd_in = 4'hA; #0.5;
    chk("R8 rxd passes before collision", rxd_out, 10);
    step();
    chk("R2 overlap 10M", col_out, 1);
    chk("R8 rxd zeroed in collision", rxd_out, 0);
    tx_act = 1'b0; sqe_evt = 1'b1; step();
    chk("R10 held by sqe", col_out, 1);
    sqe_evt = 1'b0; step();
    chk("R10 drop after sqe ends", col_out, 0);
    chk("R8 rxd restored", rxd_out, 10);
  endtask

  task automatic t_gating();
    idle();
    tx_act = 1'b1; rx_act = 1'b1; full_dpx = 1'b1; step();
    chk("R3 full duplex gates", col_out, 0);
    full_dpx = 1'b0; link_down = 1'b1; step();
    chk("R3 link down gates", col_out, 0);
    link_down = 1'b0; lpbk_en = 1'b1; spd_100 = 1'b0; jab_evt = 1'b1; step();
    chk("R3 loopback gates with jabber", col_out, 0);
  endtask

  task automatic t_events_10();
    idle();
    spd_100 = 1'b0; sqe_evt = 1'b1; step();
    chk("R5 sqe sets col", col_out, 1);
    sqe_evt = 1'b0; step();
    chk("R5 sqe release", col_out, 0);
    jab_evt = 1'b1; step();
    chk("R6 jabber sets col", col_out, 1);
    jab_evt = 1'b0; step();
    chk("R6 jabber release", col_out, 0);
  endtask

  task automatic t_events_100();
    idle();
    sqe_evt = 1'b1; jab_evt = 1'b1; rxd_in = 4'h3; step();
    chk("R7 events ignored at 100M", col_out, 0);
    chk("R9 rxd unchanged", rxd_out, 3);
  endtask

  task automatic t_col_test();
    idle();
    col_test = 1'b1; full_dpx = 1'b1; tx_en = 1'b1; #0.5;
    chk("R4 tp_tx_off high", tp_tx_off, 1);
    step();
    chk("R4 tx_en looped over gating", col_out, 1);
    tx_en = 1'b0; tx_act = 1'b1; rx_act = 1'b1; step();
    chk("R4 tx_en low ignores overlap", col_out, 0);
    col_test = 1'b0; #0.5;
    chk("R4 tp_tx_off low", tp_tx_off, 0);
  endtask

  initial begin
    t_reset();
    t_overlap_100();
    t_overlap_10();
    t_gating();
    t_events_10();
    t_events_100();
    t_col_test();
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule